// File: doc/BRIEF.md
# ISA Target Ready and Zero-Wait Handshake Controller

This block sits on the host side of an ISA expansion target that bridges to a removable card. It watches the four active-low command strobes (I/O read, I/O write, memory read, memory write). Each strobe, the address-enable line, the refresh line and the card-presence input first pass through a two-flop synchronizer. A command is taken on the synchronized falling edge of its strobe, and only when address-enable is low and a card is present. Memory commands must also arrive outside a refresh cycle. The block answers on two host outputs: an open-drain style ready line, modelled here as a "pull low" enable, and a zero-wait-state indication.

Memory writes are posted into a small internal FIFO that the card side drains through a valid/ready interface. A posted write that finds room finishes with zero wait states. A posted write that finds the FIFO full holds the ready line low until an entry drains, then stores its data and releases the line. Reads and I/O accesses hold the ready line low and start the back end, and they finish when the back end returns a one-cycle completion pulse. When the card is removed, the ready line is released at once, in the same instant and without a clock, and the access is abandoned.

Top module: `isa_wait_ctrl`

## Requirements
- R1: While reset is held and right after it, `chrdy_low_o`, `nowait_o`, `acc_start_o` and `fifo_valid_o` are all 0.
- R2: A memory write that starts with AEN low, refresh inactive, a card present and the FIFO not full sets `nowait_o` to 1 within 3 clocks. `chrdy_low_o` stays 0, and one entry holding `addr_i`/`data_i` is pushed.
- R3: `nowait_o` returns to 0 within 3 clocks after the memory-write strobe goes high.
- R4: A qualified I/O read, I/O write or memory read sets `chrdy_low_o` to 1 within 3 clocks. It also gives a one-clock `acc_start_o` pulse with `acc_kind_o` set to 0 for I/O read, 1 for I/O write and 2 for memory read.
- R5: A one-clock `done_i` pulse during a stalled read or I/O access sets `chrdy_low_o` to 0 by the next clock, even while the strobe is still low.
- R6: A command whose strobe falls while AEN is high is ignored: no `nowait_o`, no `chrdy_low_o`, no `acc_start_o` and no FIFO push.
- R7: While refresh is active (low), memory reads and writes are ignored, but I/O commands are still served.
- R8: A memory write that finds the FIFO full holds `chrdy_low_o` at 1 for as long as no entry leaves. Once an entry is popped, the write is pushed and `chrdy_low_o` returns to 0 within 3 clocks. The FIFO never accepts a push while full.
- R9: When `card_present` falls during a stalled access, `chrdy_low_o` drops to 0 without waiting for a clock, and the access is abandoned. Commands issued while no card is present are ignored.
- R10: The FIFO holds `FIFO_DEPTH` entries. It presents them in arrival order on `fifo_addr_o`/`fifo_data_o`, with `fifo_valid_o` set, and removes one on each clock where `fifo_valid_o` and `fifo_ready_i` are both 1. A presented entry stays stable while it is not accepted.
- R11: After the active strobe returns high, the block is idle again within 3 clocks and takes the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| aen | input | 1 | Address enable; high marks a DMA cycle, which must be ignored |
| refresh_n | input | 1 | Refresh indication, active low |
| card_present | input | 1 | High while a card is inserted |
| addr_i | input | AW | Latched host address for posted writes |
| data_i | input | DW | Host write data for posted writes |
| done_i | input | 1 | One-clock completion pulse from the back end |
| chrdy_low_o | output | 1 | 1 = pull the ready line low; 0 = release it (high impedance) |
| nowait_o | output | 1 | Zero-wait-state indication, active high |
| acc_start_o | output | 1 | One-clock pulse that starts a back-end access |
| acc_kind_o | output | 2 | Kind of access: 0 I/O read, 1 I/O write, 2 memory read, 3 memory write |
| fifo_valid_o | output | 1 | FIFO head entry is valid |
| fifo_ready_i | input | 1 | Card side accepts the head entry |
| fifo_addr_o | output | AW | Address of the head entry |
| fifo_data_o | output | DW | Data of the head entry |

## Verification
The bench sweeps all four strobes against both levels of AEN and refresh. A design that ignores either qualifier would stall the bus or post a phantom write during DMA or refresh, and would show a ready pull or a start pulse where none is expected. It then fills the FIFO and checks that the next write stalls until exactly one entry drains. A design that drops or overwrites the stalled write would fail the in-order drain check. The card is pulled out in the middle of a stalled read, and the ready line is sampled a fraction of a clock later. A design that waits for the synchronizer or for the strobe to end would still be pulling the line low at that point.

// File: rtl/isa_wait_pkg.sv
package isa_wait_pkg;

    localparam int STRB_N = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ZWS,
        ST_FULL,
        ST_DONE,
        ST_HOLD
    } state_e;

    // Values double as bit positions in the strobe vector.
    typedef enum logic [1:0] {
        KIND_IOR  = 2'd0,
        KIND_IOW  = 2'd1,
        KIND_MEMR = 2'd2,
        KIND_MEMW = 2'd3
    } kind_e;

    typedef struct packed {
        state_e            st;
        kind_e             kind;
        logic              pull;
        logic              nowait;
        logic              start;
        logic [STRB_N-1:0] prev;
    } ctl_t;

endpackage

// File: rtl/isa_sync.sv
module isa_sync #(
    parameter int           W       = 7,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] chain_d;
    logic [STAGES-1:0][W-1:0] chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/isa_wr_fifo.sv
module isa_wr_fifo #(
    parameter int AW    = 24,
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic          full_o,
    output logic          valid_o,
    input  logic          ready_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);

    localparam int PW = $clog2(DEPTH);
    localparam int EW = AW + DW;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [PW:0]   FULL_CNT = (PW+1)'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [PW:0]   cnt;
    } ptr_t;

    ptr_t                     ptr_d, ptr_q;
    logic [DEPTH-1:0][EW-1:0] mem_d, mem_q;
    logic                     do_push, do_pop;

    assign full_o  = (ptr_q.cnt == FULL_CNT);
    assign valid_o = (ptr_q.cnt != '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = valid_o && ready_i;
    assign {addr_o, data_o} = mem_q[ptr_q.rd];

    always_comb begin
        ptr_d = ptr_q;
        mem_d = mem_q;
        if (do_push) begin
            mem_d[ptr_q.wr] = {addr_i, data_i};
            ptr_d.wr = (ptr_q.wr == LAST) ? '0 : ptr_q.wr + 1'b1;
        end
        if (do_pop) begin
            ptr_d.rd = (ptr_q.rd == LAST) ? '0 : ptr_q.rd + 1'b1;
        end
        if (do_push && !do_pop) begin
            ptr_d.cnt = ptr_q.cnt + 1'b1;
        end else if (do_pop && !do_push) begin
            ptr_d.cnt = ptr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            mem_q <= '0;
        end else begin
            ptr_q <= ptr_d;
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/isa_wait_ctrl.sv
module isa_wait_ctrl
    import isa_wait_pkg::*;
#(
    parameter int AW          = 24,
    parameter int DW          = 16,
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ior_n,
    input  logic          iow_n,
    input  logic          memr_n,
    input  logic          memw_n,
    input  logic          aen,
    input  logic          refresh_n,
    input  logic          card_present,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic          done_i,
    output logic          chrdy_low_o,
    output logic          nowait_o,
    output logic          acc_start_o,
    output logic [1:0]    acc_kind_o,
    output logic          fifo_valid_o,
    input  logic          fifo_ready_i,
    output logic [AW-1:0] fifo_addr_o,
    output logic [DW-1:0] fifo_data_o
);

    localparam int SYNC_W = STRB_N + 3;
    localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, 1'b1, 1'b0, {STRB_N{1'b1}}};

    logic [SYNC_W-1:0] raw_in, sync_out;
    logic [STRB_N-1:0] strb_s, fall;
    logic              aen_s, refn_s, card_s, cmd_ok;
    logic              wr_push, wr_full;
    ctl_t              ctl_d, ctl_q;

    assign raw_in = {card_present, refresh_n, aen, memw_n, memr_n, iow_n, ior_n};

    isa_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_out)
    );

    assign strb_s = sync_out[STRB_N-1:0];
    assign aen_s  = sync_out[STRB_N];
    assign refn_s = sync_out[STRB_N+1];
    assign card_s = sync_out[STRB_N+2];

    isa_wr_fifo #(
        .AW    (AW),
        .DW    (DW),
        .DEPTH (FIFO_DEPTH)
    ) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (wr_push),
        .addr_i  (addr_i),
        .data_i  (data_i),
        .full_o  (wr_full),
        .valid_o (fifo_valid_o),
        .ready_i (fifo_ready_i),
        .addr_o  (fifo_addr_o),
        .data_o  (fifo_data_o)
    );

    assign fall   = ctl_q.prev & ~strb_s;
    assign cmd_ok = card_s && !aen_s;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = 1'b0;
        ctl_d.prev  = strb_s;
        wr_push     = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_ok) begin
                    if (fall[KIND_MEMW] && refn_s) begin
                        ctl_d.kind = KIND_MEMW;
                        if (!wr_full) begin
                            wr_push      = 1'b1;
                            ctl_d.st     = ST_ZWS;
                            ctl_d.nowait = 1'b1;
                        end else begin
                            ctl_d.st   = ST_FULL;
                            ctl_d.pull = 1'b1;
                        end
                    end else if (fall[KIND_MEMR] && refn_s) begin
                        ctl_d.kind  = KIND_MEMR;
                        ctl_d.st    = ST_DONE;
                        ctl_d.pull  = 1'b1;
                        ctl_d.start = 1'b1;
                    end else if (fall[KIND_IOW]) begin
                        ctl_d.kind  = KIND_IOW;
                        ctl_d.st    = ST_DONE;
                        ctl_d.pull  = 1'b1;
                        ctl_d.start = 1'b1;
                    end else if (fall[KIND_IOR]) begin
                        ctl_d.kind  = KIND_IOR;
                        ctl_d.st    = ST_DONE;
                        ctl_d.pull  = 1'b1;
                        ctl_d.start = 1'b1;
                    end
                end
            end
            ST_ZWS: begin
                if (strb_s[KIND_MEMW]) begin
                    ctl_d.st     = ST_IDLE;
                    ctl_d.nowait = 1'b0;
                end
            end
            ST_FULL: begin
                if (!card_s) begin
                    ctl_d.st   = ST_HOLD;
                    ctl_d.pull = 1'b0;
                end else if (strb_s[KIND_MEMW]) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.pull = 1'b0;
                end else if (!wr_full) begin
                    wr_push    = 1'b1;
                    ctl_d.st   = ST_HOLD;
                    ctl_d.pull = 1'b0;
                end
            end
            ST_DONE: begin
                if (!card_s || done_i) begin
                    ctl_d.st   = ST_HOLD;
                    ctl_d.pull = 1'b0;
                end else if (strb_s[ctl_q.kind]) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.pull = 1'b0;
                end
            end
            ST_HOLD: begin
                if (strb_s[ctl_q.kind]) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: begin
                ctl_d.st     = ST_IDLE;
                ctl_d.pull   = 1'b0;
                ctl_d.nowait = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            ctl_q.st     <= ST_IDLE;
            ctl_q.kind   <= KIND_IOR;
            ctl_q.prev   <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Removal releases the line without a clock edge.
    assign chrdy_low_o = ctl_q.pull && card_present;
    assign nowait_o    = ctl_q.nowait;
    assign acc_start_o = ctl_q.start;
    assign acc_kind_o  = ctl_q.kind;

endmodule

// File: rtl/isa_wait_chk.sv
module isa_wait_chk #(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          card_present,
    input logic          chrdy_low_o,
    input logic          nowait_o,
    input logic          acc_start_o,
    input logic          fifo_valid_o,
    input logic          fifo_ready_i,
    input logic [AW-1:0] fifo_addr_o,
    input logic [DW-1:0] fifo_data_o,
    input logic          wr_push,
    input logic          wr_full,
    input logic          aen_s
);

    // R8: the controller never pushes into a full FIFO
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_push && wr_full));

    // R2: zero-wait indication only starts together with a posted write
    assert_zws_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nowait_o) |-> $past(wr_push));

    // R2: a zero-wait write never pulls the ready line
    assert_zws_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(chrdy_low_o && nowait_o));

    // R4: start is a single-clock pulse
    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_start_o |=> !acc_start_o);

    // R4: a started access stalls the bus while the card is there
    assert_start_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start_o && card_present) |-> chrdy_low_o);

    // R6: nothing starts from a cycle qualified by AEN high
    assert_aen_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start_o || $rose(nowait_o)) |-> !$past(aen_s));

    // R10: an unaccepted head entry stays put
    assert_head_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_valid_o && !fifo_ready_i) |=>
            (fifo_valid_o && $stable(fifo_addr_o) && $stable(fifo_data_o)));

endmodule

bind isa_wait_ctrl isa_wait_chk #(.AW(AW), .DW(DW)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .card_present (card_present),
    .chrdy_low_o  (chrdy_low_o),
    .nowait_o     (nowait_o),
    .acc_start_o  (acc_start_o),
    .fifo_valid_o (fifo_valid_o),
    .fifo_ready_i (fifo_ready_i),
    .fifo_addr_o  (fifo_addr_o),
    .fifo_data_o  (fifo_data_o),
    .wr_push      (wr_push),
    .wr_full      (wr_full),
    .aen_s        (aen_s)
);

// File: tb/test_isa_wait_ctrl.sv
`timescale 1ns/1ps
module test_isa_wait_ctrl;

    localparam int AW = 24;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ior_n = 1'b1, iow_n = 1'b1, memr_n = 1'b1, memw_n = 1'b1;
    logic          aen = 1'b0, refresh_n = 1'b1, card_present = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] data_i = '0;
    logic          done_i = 1'b0;
    logic          chrdy_low_o, nowait_o, acc_start_o, fifo_valid_o;
    logic [1:0]    acc_kind_o;
    logic          fifo_ready_i = 1'b0;
    logic [AW-1:0] fifo_addr_o;
    logic [DW-1:0] fifo_data_o;

    int checks = 0;
    int errors = 0;
    int start_cnt = 0;
    int last_kind = -1;
    int pop_cnt = 0;
    logic [AW-1:0] exp_addr [0:15];
    logic [DW-1:0] exp_data [0:15];
    int q_head = 0;
    int q_tail = 0;

    always #4 clk = ~clk;

    isa_wait_ctrl #(.AW(AW), .DW(DW)) i_isa_wait_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n),
        .aen(aen), .refresh_n(refresh_n), .card_present(card_present),
        .addr_i(addr_i), .data_i(data_i), .done_i(done_i),
        .chrdy_low_o(chrdy_low_o), .nowait_o(nowait_o),
        .acc_start_o(acc_start_o), .acc_kind_o(acc_kind_o),
        .fifo_valid_o(fifo_valid_o), .fifo_ready_i(fifo_ready_i),
        .fifo_addr_o(fifo_addr_o), .fifo_data_o(fifo_data_o)
    );

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitors sample at the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && acc_start_o) begin
            start_cnt++;
            last_kind = int'(acc_kind_o);
        end
        if (rst_n && fifo_valid_o && fifo_ready_i) begin
            pop_cnt++;
            check_eq("R10", "pop addr", int'(fifo_addr_o), int'(exp_addr[q_head]));
            check_eq("R10", "pop data", int'(fifo_data_o), int'(exp_data[q_head]));
            q_head++;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic strobe(int c, logic v);
        case (c)
            0: ior_n = v;
            1: iow_n = v;
            2: memr_n = v;
            default: memw_n = v;
        endcase
    endtask

    task automatic zws_write(logic [AW-1:0] a, logic [DW-1:0] d);
        addr_i = a;
        data_i = d;
        exp_addr[q_tail] = a;
        exp_data[q_tail] = d;
        q_tail++;
        strobe(3, 1'b0);
        cyc(4);
        check_eq("R2", "zws write nowait", int'(nowait_o), 1);
        check_eq("R2", "zws write no stall", int'(chrdy_low_o), 0);
        strobe(3, 1'b1);
        cyc(4);
        check_eq("R3", "nowait released", int'(nowait_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        cyc(3);
        check_eq("R1", "chrdy in reset", int'(chrdy_low_o), 0);
        check_eq("R1", "nowait in reset", int'(nowait_o), 0);
        check_eq("R1", "start in reset", int'(acc_start_o), 0);
        check_eq("R1", "fifo valid in reset", int'(fifo_valid_o), 0);
        rst_n = 1'b1;
        cyc(4);
        check_eq("R1", "chrdy after reset", int'(chrdy_low_o), 0);

        // Sweep: every strobe against AEN and refresh (R2 R4 R5 R6 R7 R11)
        for (int c = 0; c < 4; c++) begin
            for (int a = 0; a < 2; a++) begin
                for (int r = 0; r < 2; r++) begin
                    bit ok;
                    int sc;
                    ok = (a == 0) && ((c < 2) || (r == 1));
                    aen = a[0];
                    refresh_n = r[0];
                    addr_i = AW'(24'h0A0000 + c * 16 + a * 4 + r);
                    data_i = DW'(16'h5000 + c * 16 + a * 4 + r);
                    cyc(3);
                    sc = start_cnt;
                    strobe(c, 1'b0);
                    cyc(4);
                    if (ok && c == 3) begin
                        exp_addr[q_tail] = addr_i;
                        exp_data[q_tail] = data_i;
                        q_tail++;
                        check_eq("R2", "sweep memw nowait", int'(nowait_o), 1);
                        check_eq("R2", "sweep memw no stall", int'(chrdy_low_o), 0);
                        check_eq("R2", "sweep memw pushed", int'(fifo_valid_o), 1);
                    end else if (ok) begin
                        check_eq("R4", "sweep stall", int'(chrdy_low_o), 1);
                        check_eq("R4", "sweep one start", start_cnt - sc, 1);
                        check_eq("R4", "sweep kind", last_kind, c);
                        if (c == 2 || r == 0) begin
                            check_eq("R7", "io or memr served", int'(chrdy_low_o), 1);
                        end
                        done_i = 1'b1;
                        cyc(1);
                        done_i = 1'b0;
                        cyc(1);
                        check_eq("R5", "released by done", int'(chrdy_low_o), 0);
                        cyc(2);
                        check_eq("R5", "stays released", int'(chrdy_low_o), 0);
                    end else begin
                        string tag;
                        tag = (a == 1) ? "R6" : "R7";
                        check_eq(tag, "ignored no stall", int'(chrdy_low_o), 0);
                        check_eq(tag, "ignored no nowait", int'(nowait_o), 0);
                        check_eq(tag, "ignored no start", start_cnt - sc, 0);
                        if (c == 3 && q_tail == 0) begin
                            check_eq(tag, "ignored no push", int'(fifo_valid_o), 0);
                        end
                    end
                    strobe(c, 1'b1);
                    cyc(4);
                    check_eq("R11", "idle nowait", int'(nowait_o), 0);
                    check_eq("R11", "idle chrdy", int'(chrdy_low_o), 0);
                end
            end
        end
        aen = 1'b0;
        refresh_n = 1'b1;
        cyc(3);

        // Fill the FIFO, then stall (R2 R3 R8 R10)
        for (int k = q_tail; k < 4; k++) begin
            zws_write(AW'(24'h300000 + k), DW'(16'h9100 + k));
        end
        addr_i = 24'h3ABCDE;
        data_i = 16'hBEEF;
        exp_addr[q_tail] = addr_i;
        exp_data[q_tail] = data_i;
        q_tail++;
        strobe(3, 1'b0);
        cyc(4);
        check_eq("R8", "full write stalls", int'(chrdy_low_o), 1);
        check_eq("R8", "full write no nowait", int'(nowait_o), 0);
        cyc(8);
        check_eq("R8", "still stalled", int'(chrdy_low_o), 1);
        fifo_ready_i = 1'b1;
        cyc(1);
        fifo_ready_i = 1'b0;
        cyc(2);
        check_eq("R8", "released after drain", int'(chrdy_low_o), 0);
        check_eq("R8", "one pop", pop_cnt, 1);
        strobe(3, 1'b1);
        cyc(4);
        check_eq("R11", "idle after full write", int'(chrdy_low_o), 0);
        fifo_ready_i = 1'b1;
        cyc(8);
        fifo_ready_i = 1'b0;
        cyc(1);
        check_eq("R10", "all entries drained", pop_cnt, 5);
        check_eq("R10", "fifo empty", int'(fifo_valid_o), 0);

        // Card removal mid-access (R9)
        begin
            int sc;
            strobe(0, 1'b0);
            cyc(4);
            check_eq("R9", "read stalls before removal", int'(chrdy_low_o), 1);
            card_present = 1'b0;
            #1;
            check_eq("R9", "immediate release", int'(chrdy_low_o), 0);
            cyc(5);
            check_eq("R9", "stays released", int'(chrdy_low_o), 0);
            strobe(0, 1'b1);
            cyc(4);
            sc = start_cnt;
            strobe(1, 1'b0);
            cyc(4);
            check_eq("R9", "no card no stall", int'(chrdy_low_o), 0);
            check_eq("R9", "no card no start", start_cnt - sc, 0);
            strobe(1, 1'b1);
            card_present = 1'b1;
            cyc(4);
            strobe(2, 1'b0);
            cyc(4);
            check_eq("R11", "served after reinsertion", int'(chrdy_low_o), 1);
            done_i = 1'b1;
            cyc(1);
            done_i = 1'b0;
            strobe(2, 1'b1);
            cyc(4);
            check_eq("R5", "final release", int'(chrdy_low_o), 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule